// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank Tracking

This block is the control front end of a device-side model of a four-bank double-data-rate SDRAM. On every rising clock edge it samples clock enable, chip select, the three active-low command strobes, a two-bit bank address and an eleven-bit address bus. It decodes activate, read, write, precharge, auto refresh and no-operation, and judges each command against the state it keeps for every bank: idle or active, and the row held open.

Every result is registered. A strobe marks a legal command, a separate flag marks an illegal one, and the decoded kind, bank, row, column and the address-bit-8 qualifier are presented alongside. Read and write start a burst timer. When auto-precharge was asked for, the addressed bank closes on the edge after the burst's last clock. A deselected chip takes no new command, but a running burst and its pending close carry on. Sampling clock enable low is reported as a low-power entry request, and the command on the pins is dropped.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: After reset all banks are idle, no strobe or illegal flag is raised, the burst indicator is low and the low-power request is low.
- R2: With clock enable high and chip select low, {ras_n,cas_n,we_n} decodes as 011 activate, 101 read, 100 write, 010 precharge, 001 auto refresh. Every other pattern is a no-operation. The result appears one clock after the sampling edge on cmd_kind as 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 0 none.
- R3: While chip select is high, no strobe or illegal flag results and no bank state changes. A running burst keeps counting and completes its auto-precharge.
- R4: Clock enable sampled low raises lp_req for one clock and drops the command on the pins.
- R5: An activate to an idle bank opens it and stores addr[10:0] as its row, reported on cmd_row.
- R6: A read or write to an open bank strobes with cmd_col = addr[7:0] and cmd_row = that bank's open row. burst_active is then high for BURST_LEN/2 clocks.
- R7: addr[8] high on a read or write closes the bank on the edge that follows the burst's last clock. It is reported on cmd_flag. addr[8] low leaves the bank open.
- R8: A precharge with addr[8] low closes only the addressed bank. With addr[8] high it closes all banks, whatever the bank address.
- R9: Auto refresh is legal only while every bank is idle. Otherwise it is illegal.
- R10: An activate to an open bank, or a read or write to an idle bank, raises the illegal flag instead of the strobe and changes no bank state.
- R11: A read or write to a bank whose auto-precharge is still pending is illegal.
- R12: A legal read or write during a burst with pending auto-precharge closes the earlier bank on that edge and restarts the burst timer.
- R13: A precharge that closes a bank with a pending auto-precharge cancels it, so a bank reopened before the burst ends stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; low requests a low-power entry |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 11 | Row on activate; column plus bit-8 qualifier otherwise |
| cmd_valid | output | 1 | One-clock strobe for a legal command |
| illegal | output | 1 | One-clock flag for an illegal command |
| cmd_kind | output | 3 | Decoded kind (R2 encoding) |
| cmd_bank | output | 2 | Target bank of the last command |
| cmd_row | output | 11 | Row opened, or row addressed by read/write |
| cmd_col | output | 8 | Column of the last read/write |
| cmd_flag | output | 1 | addr[8] of read, write or precharge |
| bank_open | output | 4 | Per-bank open flags |
| burst_active | output | 1 | High while a burst runs |
| lp_req | output | 1 | Low-power entry request |

## Verification
The bench times auto-precharge to the exact clock. A design that closed the bank when the strobe rose, or one clock late, shows a wrong bank_open either at the burst's last clock or on the clock after it. An interrupting write is checked to close the earlier bank at once and to lengthen the burst. A design that ignored the interruption would leave that bank open and end burst_active early. The bench reopens a bank after a precharge has cancelled its pending close. A design that kept the stale close would shut that bank a few clocks later. It also drives deselects during a burst, where a block that froze its timer would never close the bank.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_kind_e;

  // Active-low strobe pattern to command kind
  function automatic cmd_kind_e decode_pins(input logic ras_n, input logic cas_n,
                                            input logic we_n);
    cmd_kind_e k;
    case ({ras_n, cas_n, we_n})
      3'b011:  k = CMD_ACT;
      3'b101:  k = CMD_RD;
      3'b100:  k = CMD_WR;
      3'b010:  k = CMD_PRE;
      3'b001:  k = CMD_REF;
      default: k = CMD_NOP;
    endcase
    return k;
  endfunction

  function automatic logic is_column_cmd(input cmd_kind_e k);
    return (k == CMD_RD) || (k == CMD_WR);
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
(
  input  logic      cke,
  input  logic      cs_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  output cmd_kind_e kind,
  output logic      take,
  output logic      lp
);

  assign kind = decode_pins(ras_n, cas_n, we_n);
  assign lp   = ~cke;
  assign take = cke & ~cs_n & (kind != CMD_NOP);

endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 11
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_BANKS-1:0]              set_mask,
  input  logic [NUM_BANKS-1:0]              clr_mask,
  input  logic [ROW_W-1:0]                  row_in,
  output logic [NUM_BANKS-1:0]              open_q,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]   rows_q
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
        rows_q[b] <= '0;
      end else begin
        if (clr_mask[b]) open_q[b] <= 1'b0;
        if (set_mask[b]) begin
          open_q[b] <= 1'b1;
          rows_q[b] <= row_in;
        end
      end
    end
  end

endmodule

// File: rtl/sdram_burst_track.sv
module sdram_burst_track #(
  parameter int BURST_CYC = 4,
  parameter int BANK_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_ap,
  input  logic [BANK_W-1:0] start_bank,
  input  logic              cancel,
  output logic              active,
  output logic              ap_pend,
  output logic [BANK_W-1:0] ap_bank,
  output logic              close_evt
);

  localparam int CNT_W = $clog2(BURST_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  assign active    = (cnt_q != '0);
  // pending close fires at natural end or when a new burst interrupts
  assign close_evt = ap_pend & (start | (cnt_q == CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ap_pend <= 1'b0;
      ap_bank <= '0;
    end else if (start) begin
      cnt_q   <= CNT_W'(BURST_CYC);
      ap_pend <= start_ap;
      ap_bank <= start_bank;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
      if (close_evt || cancel) ap_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int AP_BIT    = 8,
  parameter int BURST_LEN = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cke,
  input  logic                          cs_n,
  input  logic                          ras_n,
  input  logic                          cas_n,
  input  logic                          we_n,
  input  logic [$clog2(NUM_BANKS)-1:0]  ba,
  input  logic [ROW_W-1:0]              addr,
  output logic                          cmd_valid,
  output logic                          illegal,
  output logic [2:0]                    cmd_kind,
  output logic [$clog2(NUM_BANKS)-1:0]  cmd_bank,
  output logic [ROW_W-1:0]              cmd_row,
  output logic [COL_W-1:0]              cmd_col,
  output logic                          cmd_flag,
  output logic [NUM_BANKS-1:0]          bank_open,
  output logic                          burst_active,
  output logic                          lp_req
);

  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int BURST_CYC = (BURST_LEN / 2 > 0) ? BURST_LEN / 2 : 1;

  function automatic logic [NUM_BANKS-1:0] bank_onehot(input logic [BANK_W-1:0] b);
    logic [NUM_BANKS-1:0] m;
    m    = '0;
    m[b] = 1'b1;
    return m;
  endfunction

  // decoded command
  cmd_kind_e kind;
  logic      take, lp;

  sdram_cmd_decode u_decode (
    .cke  (cke),
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .kind (kind),
    .take (take),
    .lp   (lp)
  );

  // bank state
  logic [NUM_BANKS-1:0]            open_q;
  logic [NUM_BANKS-1:0][ROW_W-1:0] rows_q;
  logic [NUM_BANKS-1:0]            set_mask, clr_mask, pre_mask, close_mask;

  // burst state, exposed as named events
  logic              ap_pend, close_evt, burst_on;
  logic [BANK_W-1:0] ap_bank;
  logic              burst_start, ap_cancel;

  logic sel_open, ap_hit, bad, go, rej, ap_bit;

  assign sel_open = open_q[ba];
  assign ap_hit   = ap_pend & (ap_bank == ba);
  assign ap_bit   = addr[AP_BIT];

  always_comb begin
    case (kind)
      CMD_ACT: bad = sel_open;
      CMD_RD,
      CMD_WR:  bad = ~sel_open | ap_hit;
      CMD_REF: bad = |open_q;
      default: bad = 1'b0;
    endcase
  end

  assign go  = take & ~bad;
  assign rej = take & bad;

  assign set_mask    = (go && kind == CMD_ACT) ? bank_onehot(ba) : '0;
  assign pre_mask    = (go && kind == CMD_PRE) ? (ap_bit ? '1 : bank_onehot(ba)) : '0;
  assign close_mask  = close_evt ? bank_onehot(ap_bank) : '0;
  assign clr_mask    = pre_mask | close_mask;
  assign burst_start = go & is_column_cmd(kind);
  assign ap_cancel   = go & (kind == CMD_PRE) & (ap_bit | (ba == ap_bank));

  sdram_bank_table #(
    .NUM_BANKS(NUM_BANKS),
    .ROW_W    (ROW_W)
  ) u_banks (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_mask(set_mask),
    .clr_mask(clr_mask),
    .row_in  (addr),
    .open_q  (open_q),
    .rows_q  (rows_q)
  );

  sdram_burst_track #(
    .BURST_CYC(BURST_CYC),
    .BANK_W   (BANK_W)
  ) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (burst_start),
    .start_ap  (ap_bit),
    .start_bank(ba),
    .cancel    (ap_cancel),
    .active    (burst_on),
    .ap_pend   (ap_pend),
    .ap_bank   (ap_bank),
    .close_evt (close_evt)
  );

  // registered command report
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      illegal   <= 1'b0;
      cmd_kind  <= 3'(CMD_NOP);
      cmd_bank  <= '0;
      cmd_row   <= '0;
      cmd_col   <= '0;
      cmd_flag  <= 1'b0;
      lp_req    <= 1'b0;
    end else begin
      cmd_valid <= go;
      illegal   <= rej;
      lp_req    <= lp;
      cmd_kind  <= take ? 3'(kind) : 3'(CMD_NOP);
      if (take) begin
        cmd_bank <= ba;
        cmd_flag <= (is_column_cmd(kind) || kind == CMD_PRE) ? ap_bit : 1'b0;
        if (kind == CMD_ACT) cmd_row <= addr;
        if (is_column_cmd(kind)) begin
          cmd_row <= rows_q[ba];
          cmd_col <= addr[COL_W-1:0];
        end
      end
    end
  end

  assign bank_open    = open_q;
  assign burst_active = burst_on;

endmodule

// File: rtl/sdram_cmd_ctrl_chk.sv
module sdram_cmd_ctrl_chk
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cke,
  input logic                 cs_n,
  input logic                 cmd_valid,
  input logic                 illegal,
  input logic [2:0]           cmd_kind,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic                 cmd_flag,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic                 burst_active,
  input logic                 lp_req,
  input logic                 ap_close_evt,
  input logic [BANK_W-1:0]    ap_bank_w
);

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && illegal)); // R10

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!cmd_valid && !illegal)); // R3

  AST_CKE_LOW_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> (lp_req && !cmd_valid && !illegal)); // R4

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == CMD_ACT) |-> bank_open[cmd_bank]); // R5

  AST_RW_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_kind == CMD_RD || cmd_kind == CMD_WR))
      |-> (burst_active && bank_open[cmd_bank])); // R6

  AST_AP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    ap_close_evt |=> !bank_open[$past(ap_bank_w)]); // R7

  AST_PREALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == CMD_PRE && cmd_flag) |-> (bank_open == '0)); // R8

  AST_REF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == CMD_REF) |-> (bank_open == '0)); // R9

endmodule

bind sdram_cmd_ctrl sdram_cmd_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cke         (cke),
  .cs_n        (cs_n),
  .cmd_valid   (cmd_valid),
  .illegal     (illegal),
  .cmd_kind    (cmd_kind),
  .cmd_bank    (cmd_bank),
  .cmd_flag    (cmd_flag),
  .bank_open   (bank_open),
  .burst_active(burst_active),
  .lp_req      (lp_req),
  .ap_close_evt(close_evt),
  .ap_bank_w   (ap_bank)
);

// File: tb/sdram_cmd_ctrl_bench.sv
module sdram_cmd_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [10:0] addr = '0;
  logic        cmd_valid, illegal, cmd_flag, burst_active, lp_req;
  logic [2:0]  cmd_kind;
  logic [1:0]  cmd_bank;
  logic [10:0] cmd_row;
  logic [7:0]  cmd_col;
  logic [3:0]  bank_open;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_ctrl u_sdram_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_valid(cmd_valid), .illegal(illegal), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .cmd_flag(cmd_flag), .bank_open(bank_open),
    .burst_active(burst_active), .lp_req(lp_req)
  );

  typedef struct {
    string       tag;
    logic        valid, ill, lp, burst, flag;
    logic [2:0]  kind;
    logic [1:0]  bank;
    logic [10:0] row;
    logic [7:0]  col;
    logic [3:0]  open;
  } exp_t;

  exp_t exp_q[$];

  task automatic check(input string tag, input string what, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // driver: one command per clock, expected result queued
  task automatic drive(input string tag, input logic ck, input logic cs,
                       input logic [2:0] rcw, input logic [1:0] b, input logic [10:0] a,
                       input logic e_valid, input logic e_ill, input logic [2:0] e_kind,
                       input logic [3:0] e_open, input logic e_burst,
                       input logic [10:0] e_row, input logic [7:0] e_col);
    exp_t e;
    @(negedge clk);
    cke = ck; cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
    e.tag = tag; e.valid = e_valid; e.ill = e_ill; e.kind = e_kind;
    e.lp = ~ck; e.burst = e_burst; e.open = e_open; e.bank = b;
    e.row = e_row; e.col = e_col;
    e.flag = (e_kind >= 3'd2 && e_kind <= 3'd4) ? a[8] : 1'b0;
    exp_q.push_back(e);
  endtask

  task automatic nop(input string tag, input logic [3:0] o, input logic bu);
    drive(tag, 1, 0, 3'b111, 0, 0, 0, 0, 0, o, bu, 0, 0);
  endtask

  task automatic desel(input string tag, input logic [3:0] o, input logic bu);
    drive(tag, 1, 1, 3'b011, 2'd3, 11'h0F0, 0, 0, 0, o, bu, 0, 0);
  endtask

  task automatic act(input string tag, input logic [1:0] b, input logic [10:0] r,
                     input logic ok, input logic [3:0] o, input logic bu);
    drive(tag, 1, 0, 3'b011, b, r, ok, !ok, 3'd1, o, bu, r, 0);
  endtask

  task automatic rw(input string tag, input logic wr, input logic [1:0] b,
                    input logic [7:0] c, input logic ap, input logic ok,
                    input logic [10:0] r, input logic [3:0] o, input logic bu);
    drive(tag, 1, 0, wr ? 3'b100 : 3'b101, b, {2'b00, ap, c}, ok, !ok,
          wr ? 3'd3 : 3'd2, o, bu, r, c);
  endtask

  task automatic pre(input string tag, input logic [1:0] b, input logic all,
                     input logic [3:0] o, input logic bu);
    drive(tag, 1, 0, 3'b010, b, {2'b00, all, 8'h00}, 1, 0, 3'd4, o, bu, 0, 0);
  endtask

  task automatic refr(input string tag, input logic ok, input logic [3:0] o, input logic bu);
    drive(tag, 1, 0, 3'b001, 0, 0, ok, !ok, 3'd5, o, bu, 0, 0);
  endtask

  // monitor: samples a quarter period after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, "cmd_valid", cmd_valid, e.valid);
        check(e.tag, "illegal", illegal, e.ill);
        check(e.tag, "lp_req", lp_req, e.lp);
        check(e.tag, "bank_open", bank_open, e.open);
        check(e.tag, "burst_active", burst_active, e.burst);
        if (e.valid || e.ill) check(e.tag, "cmd_kind", cmd_kind, e.kind);
        else                  check(e.tag, "cmd_kind", cmd_kind, 0);
        if (e.valid) begin
          check(e.tag, "cmd_bank", cmd_bank, e.bank);
          check(e.tag, "cmd_flag", cmd_flag, e.flag);
          if (e.kind >= 3'd1 && e.kind <= 3'd3) check(e.tag, "cmd_row", cmd_row, e.row);
          if (e.kind == 3'd2 || e.kind == 3'd3) check(e.tag, "cmd_col", cmd_col, e.col);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset", "outputs", {cmd_valid, illegal, burst_active, lp_req}, 0);
    check("R1 reset", "bank_open", bank_open, 0);
    nop("R1 idle nop", 4'b0000, 0);

    act("R5 act b0", 0, 11'h155, 1, 4'b0001, 0);
    act("R5 act b2", 2, 11'h7FF, 1, 4'b0101, 0);
    act("R10 act open b0", 0, 11'h001, 0, 4'b0101, 0);
    rw("R6 rd b0", 0, 0, 8'hA5, 0, 1, 11'h155, 4'b0101, 1);
    nop("R6 beat2", 4'b0101, 1);
    nop("R6 beat3", 4'b0101, 1);
    nop("R6 beat4", 4'b0101, 1);
    nop("R6 burst over", 4'b0101, 0);
    rw("R10 wr idle b1", 1, 1, 8'h10, 0, 0, 0, 4'b0101, 0);
    rw("R7 wr b2 ap", 1, 2, 8'h3C, 1, 1, 11'h7FF, 4'b0101, 1);
    nop("R7 beat2", 4'b0101, 1);
    nop("R7 beat3", 4'b0101, 1);
    nop("R7 last beat still open", 4'b0101, 1);
    nop("R7 closed after burst", 4'b0001, 0);
    refr("R9 ref with open bank", 0, 4'b0001, 0);
    desel("R3 deselected act b3", 4'b0001, 0);
    drive("R4 cke low act b3", 0, 0, 3'b011, 3, 11'h0AA, 0, 0, 0, 4'b0001, 0, 0, 0);
    drive("R2 unsupported 000", 1, 0, 3'b000, 3, 11'h0AA, 0, 0, 0, 4'b0001, 0, 0, 0);
    drive("R2 unsupported 110", 1, 0, 3'b110, 3, 11'h0AA, 0, 0, 0, 4'b0001, 0, 0, 0);

    rw("R3 rd b0 ap", 0, 0, 8'h11, 1, 1, 11'h155, 4'b0001, 1);
    desel("R3 burst runs desel", 4'b0001, 1);
    desel("R3 burst runs desel", 4'b0001, 1);
    desel("R3 burst runs desel", 4'b0001, 1);
    desel("R3 ap done while desel", 4'b0000, 0);
    refr("R9 ref all idle", 1, 4'b0000, 0);

    act("R8 act b1", 1, 11'h022, 1, 4'b0010, 0);
    act("R8 act b3", 3, 11'h300, 1, 4'b1010, 0);
    pre("R8 pre b1 only", 1, 0, 4'b1000, 0);
    act("R8 act b1 again", 1, 11'h023, 1, 4'b1010, 0);
    pre("R8 pre all", 0, 1, 4'b0000, 0);

    act("R12 act b0", 0, 11'h100, 1, 4'b0001, 0);
    act("R12 act b1", 1, 11'h200, 1, 4'b0011, 0);
    rw("R12 rd b0 ap", 0, 0, 8'h01, 1, 1, 11'h100, 4'b0011, 1);
    rw("R12 wr b1 interrupts", 1, 1, 8'h05, 0, 1, 11'h200, 4'b0010, 1);
    nop("R12 restarted", 4'b0010, 1);
    nop("R12 restarted", 4'b0010, 1);
    nop("R12 past old end", 4'b0010, 1);
    nop("R12 new burst over", 4'b0010, 0);

    rw("R11 rd b1 ap", 0, 1, 8'h07, 1, 1, 11'h200, 4'b0010, 1);
    rw("R11 rd pending b1", 0, 1, 8'h08, 0, 0, 0, 4'b0010, 1);
    nop("R11 beat3", 4'b0010, 1);
    nop("R11 beat4", 4'b0010, 1);
    nop("R11 ap closes b1", 4'b0000, 0);

    act("R13 act b2", 2, 11'h0AA, 1, 4'b0100, 0);
    rw("R13 wr b2 ap", 1, 2, 8'h09, 1, 1, 11'h0AA, 4'b0100, 1);
    pre("R13 pre b2 cancels", 2, 0, 4'b0000, 1);
    act("R13 reopen b2", 2, 11'h0AB, 1, 4'b0100, 1);
    nop("R13 beat4", 4'b0100, 1);
    nop("R13 stays open", 4'b0100, 0);
    nop("R13 stays open", 4'b0100, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule